// File: doc/BRIEF.md
# Row Tridiagonal Solver

This block solves one tridiagonal linear system per image row using forward elimination followed by back substitution, all in signed fixed point. Each row arrives as a stream of elements; element i carries the main-diagonal coefficient a(i), the coefficient right of the diagonal b(i), the coefficient below the diagonal c(i) and the right-hand side d(i). A start marker tags element 1 and an end marker tags the final element. Because every row is an independent system, the only storage the block needs is a handful of buffers one row long.

While a row streams in, the block runs two forward recurrences. One produces the eliminated pivots m(i). The other produces the modified right-hand side y(i). Every pivot ratio comes from one shared iterative divider, and the block holds its input off through a ready signal while that divider works. After the final element it walks the stored pivots, super-diagonal entries and modified right-hand sides from the highest index down to the lowest, dividing at every step. It then streams the solution u(1..n) in ascending order, with a valid flag and a last flag.

Top module: `tridiag_row_solver`

## Requirements
- R1: Words are signed two's complement, W bits wide with FRAC fraction bits (defaults 16 and 8). A product is the full product shifted right arithmetically by FRAC, which rounds toward minus infinity. Every product and difference is clamped to the range -2^(W-1) .. 2^(W-1)-1.
- R2: The forward pass sets m(1)=a(1) and y(1)=d(1). For i>1 it computes m(i)=a(i)-r(i-1)*b(i-1) and y(i)=d(i)-r(i-1)*y(i-1), where r(k)=c(k)/m(k).
- R3: A quotient p/q equals p*2^FRAC/q truncated toward zero, then clamped as in R1. The b and c of the final element of a row have no effect on the solution.
- R4: The backward pass sets u(n)=y(n)/m(n). For i<n it computes u(i)=(y(i)-b(i)*u(i+1))/m(i).
- R5: An element accepted with inStart high always becomes element 1 of a new row, and any partially received row is discarded.
- R6: A row ends with the element that has inEnd high, or with the N-th element, whichever comes first. A row may hold a single element.
- R7: inReady is low in the cycle after any element is accepted. It stays low while a division is pending, and through the backward pass and the output burst up to the last solution word.
- R8: The solution leaves as n consecutive outValid cycles in ascending index order. outLast is high only on u(n), and no output follows within the row.
- R9: A division by zero returns 0x7FFF when the dividend is zero or positive and 0x8000 when it is negative.
- R10: During and right after reset, inReady is 1 and outValid and outLast are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Element present on the coefficient inputs |
| inReady | output | 1 | Block accepts an element this cycle |
| inStart | input | 1 | Marks element 1 of a row |
| inEnd | input | 1 | Marks the final element of a row |
| inAlpha | input | W | Main-diagonal coefficient a(i) |
| inBeta | input | W | Super-diagonal coefficient b(i) |
| inGamma | input | W | Sub-diagonal coefficient c(i) |
| inD | input | W | Right-hand side d(i) |
| outValid | output | 1 | Solution word present |
| outLast | output | 1 | Solution word is u(n) |
| outData | output | W | Solution word u(i) |

## Verification
The solver is tried on three full-length rows. The first is diagonally dominant with positive terms, so ordinary values flow through both passes. The second has negative pivots and fractional off-diagonal terms, which makes the flooring of products differ from the truncation of quotients. The third has a tiny pivot and huge off-diagonal values, which pushes intermediate results into clamping. A row repeated with altered final b and c shows whether those inputs leak into the result. A row restarted partway shows whether the forward state is cleared. Short rows and single-element rows with zero pivots tell apart the end-marker path, the length-limit path and the two signs of divide-by-zero saturation.

// File: rtl/tridiag_pkg.sv
package tridiag_pkg;

  typedef struct packed {
    logic accept;
    logic first;
    logic fwdDivGo;
    logic bwdDivGo;
    logic bwdLastSel;
    logic lLoad;
    logic uLoad;
    logic emit;
    logic emitLast;
  } tdsCtrl_t;

  typedef enum logic [2:0] {
    ST_FWD    = 3'd0,
    ST_FDIV   = 3'd1,
    ST_BISSUE = 3'd2,
    ST_BDIV   = 3'd3,
    ST_OUT    = 3'd4
  } tdsState_t;

endpackage

// File: rtl/tridiag_divider.sv
module tridiag_divider #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic signed [W-1:0] num,
  input  logic signed [W-1:0] den,
  output logic                done,
  output logic signed [W-1:0] quot
);
  localparam int DW = W + FRAC;
  localparam int CW = $clog2(DW + 1);
  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [DW-1:0] POS_LIM = DW'((1 << (W-1)) - 1);
  localparam logic [DW-1:0] NEG_LIM = DW'(1 << (W-1));

  logic          busy;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rem;
  logic [DW-1:0] quo;
  logic [W-1:0]  dvsr;
  logic          negRes;
  logic          negNum;
  logic          zeroDen;

  logic [W-1:0] numMag;
  logic [W-1:0] denMag;
  logic [W:0]   remShift;
  logic [W:0]   dvsrExt;
  logic         geq;

  assign numMag   = num[W-1] ? (~num + 1'b1) : num;
  assign denMag   = den[W-1] ? (~den + 1'b1) : den;
  assign remShift = {rem, quo[DW-1]};
  assign dvsrExt  = {1'b0, dvsr};
  assign geq      = remShift >= dvsrExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      rem     <= '0;
      quo     <= '0;
      dvsr    <= '0;
      negRes  <= 1'b0;
      negNum  <= 1'b0;
      zeroDen <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      cnt     <= CW'(DW);
      rem     <= '0;
      quo     <= {numMag, {FRAC{1'b0}}};
      dvsr    <= denMag;
      negRes  <= num[W-1] ^ den[W-1];
      negNum  <= num[W-1];
      zeroDen <= (den == '0);
      done    <= 1'b0;
    end else if (busy) begin
      rem  <= geq ? W'(remShift - dvsrExt) : remShift[W-1:0];
      quo  <= {quo[DW-2:0], geq};
      cnt  <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  always_comb begin
    if (zeroDen) begin
      quot = negNum ? SMIN : SMAX;
    end else if (negRes) begin
      quot = (quo > NEG_LIM) ? SMIN : $signed(~quo[W-1:0] + 1'b1);
    end else begin
      quot = (quo > POS_LIM) ? SMAX : $signed(quo[W-1:0]);
    end
  end

endmodule

// File: rtl/tridiag_datapath.sv
module tridiag_datapath
  import tridiag_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int N    = 100,
  parameter int IW   = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  tdsCtrl_t            ctrl,
  input  logic [IW-1:0]       wIdx,
  input  logic [IW-1:0]       rIdx,
  input  logic [IW-1:0]       oIdx,
  input  logic signed [W-1:0] inAlpha,
  input  logic signed [W-1:0] inBeta,
  input  logic signed [W-1:0] inGamma,
  input  logic signed [W-1:0] inD,
  output logic                divDone,
  output logic                outValid,
  output logic                outLast,
  output logic signed [W-1:0] outData
);
  localparam int XW = 2 * W;
  localparam logic signed [XW-1:0] HI = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] LO = {{(W+1){1'b1}}, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] satW(input logic signed [XW-1:0] v);
    if (v > HI)      return HI[W-1:0];
    else if (v < LO) return LO[W-1:0];
    else             return v[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] fMul(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    logic signed [XW-1:0] p;
    p = a * b;
    return satW(p >>> FRAC);
  endfunction

  function automatic logic signed [W-1:0] fSub(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    logic signed [XW-1:0] s;
    s = a - b;
    return satW(s);
  endfunction

  logic signed [W-1:0] mBuf    [N];
  logic signed [W-1:0] betaBuf [N];
  logic signed [W-1:0] yBuf    [N];
  logic signed [W-1:0] uBuf    [N];

  logic signed [W-1:0] lPrev, betaPrev, yPrev, uNext;
  logic signed [W-1:0] mNow, yNow;
  logic signed [W-1:0] mR, betaR, yR, bwdNum;
  logic signed [W-1:0] divNum, divDen, divQuot;
  logic                divStart;

  assign mNow = ctrl.first ? inAlpha : fSub(inAlpha, fMul(lPrev, betaPrev));
  assign yNow = ctrl.first ? inD     : fSub(inD, fMul(lPrev, yPrev));

  assign mR     = mBuf[rIdx];
  assign betaR  = betaBuf[rIdx];
  assign yR     = yBuf[rIdx];
  assign bwdNum = ctrl.bwdLastSel ? yR : fSub(yR, fMul(betaR, uNext));

  assign divStart = ctrl.fwdDivGo | ctrl.bwdDivGo;
  assign divNum   = ctrl.fwdDivGo ? inGamma : bwdNum;
  assign divDen   = ctrl.fwdDivGo ? mNow : mR;

  tridiag_divider #(.W(W), .FRAC(FRAC)) uDiv (
    .clk  (clk),
    .rstN (rstN),
    .start(divStart),
    .num  (divNum),
    .den  (divDen),
    .done (divDone),
    .quot (divQuot)
  );

  always_ff @(posedge clk) begin
    if (ctrl.accept) begin
      mBuf[wIdx]    <= mNow;
      betaBuf[wIdx] <= inBeta;
      yBuf[wIdx]    <= yNow;
    end
    if (ctrl.uLoad) begin
      uBuf[rIdx] <= divQuot;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lPrev    <= '0;
      betaPrev <= '0;
      yPrev    <= '0;
      uNext    <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outData  <= '0;
    end else begin
      if (ctrl.accept) begin
        betaPrev <= inBeta;
        yPrev    <= yNow;
      end
      if (ctrl.lLoad) lPrev <= divQuot;
      if (ctrl.uLoad) uNext <= divQuot;
      outValid <= ctrl.emit;
      outLast  <= ctrl.emitLast;
      outData  <= ctrl.emit ? uBuf[oIdx] : '0;
    end
  end

endmodule

// File: rtl/tridiag_control.sv
module tridiag_control
  import tridiag_pkg::*;
#(
  parameter int N  = 100,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inStart,
  input  logic          inEnd,
  input  logic          divDone,
  output logic          inReady,
  output tdsCtrl_t      ctrl,
  output logic [IW-1:0] wIdx,
  output logic [IW-1:0] rIdx,
  output logic [IW-1:0] oIdx
);
  tdsState_t     state;
  logic [IW-1:0] cnt;
  logic [IW-1:0] lastIdx;
  logic [IW-1:0] bIdx;
  logic [IW-1:0] oIdxR;

  logic [IW-1:0] idx;
  logic          isLast;

  assign idx     = inStart ? '0 : cnt;
  assign isLast  = inEnd || (idx == IW'(N - 1));
  assign inReady = (state == ST_FWD);
  assign wIdx    = idx;
  assign rIdx    = bIdx;
  assign oIdx    = oIdxR;

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_FWD: begin
        if (inValid) begin
          ctrl.accept   = 1'b1;
          ctrl.first    = inStart || (cnt == '0);
          ctrl.fwdDivGo = !isLast;
        end
      end
      ST_FDIV:   ctrl.lLoad = divDone;
      ST_BISSUE: begin
        ctrl.bwdDivGo   = 1'b1;
        ctrl.bwdLastSel = (bIdx == lastIdx);
      end
      ST_BDIV:   ctrl.uLoad = divDone;
      ST_OUT: begin
        ctrl.emit     = 1'b1;
        ctrl.emitLast = (oIdxR == lastIdx);
      end
      default: ctrl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_FWD;
      cnt     <= '0;
      lastIdx <= '0;
      bIdx    <= '0;
      oIdxR   <= '0;
    end else begin
      unique case (state)
        ST_FWD: begin
          if (inValid) begin
            if (isLast) begin
              lastIdx <= idx;
              bIdx    <= idx;
              cnt     <= '0;
              state   <= ST_BISSUE;
            end else begin
              cnt   <= idx + 1'b1;
              state <= ST_FDIV;
            end
          end
        end
        ST_FDIV: begin
          if (divDone) state <= ST_FWD;
        end
        ST_BISSUE: state <= ST_BDIV;
        ST_BDIV: begin
          if (divDone) begin
            if (bIdx == '0) begin
              oIdxR <= '0;
              state <= ST_OUT;
            end else begin
              bIdx  <= bIdx - 1'b1;
              state <= ST_BISSUE;
            end
          end
        end
        ST_OUT: begin
          if (oIdxR == lastIdx) state <= ST_FWD;
          else                  oIdxR <= oIdxR + 1'b1;
        end
        default: state <= ST_FWD;
      endcase
    end
  end

endmodule

// File: rtl/tridiag_row_solver.sv
module tridiag_row_solver
  import tridiag_pkg::*;
#(
  parameter int N    = 100,
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic                inStart,
  input  logic                inEnd,
  input  logic signed [W-1:0] inAlpha,
  input  logic signed [W-1:0] inBeta,
  input  logic signed [W-1:0] inGamma,
  input  logic signed [W-1:0] inD,
  output logic                outValid,
  output logic                outLast,
  output logic signed [W-1:0] outData
);
  localparam int IW = $clog2(N + 1);

  tdsCtrl_t      ctrl;
  logic [IW-1:0] wIdx, rIdx, oIdx;
  logic          divDone;

  tridiag_control #(.N(N), .IW(IW)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inStart(inStart),
    .inEnd  (inEnd),
    .divDone(divDone),
    .inReady(inReady),
    .ctrl   (ctrl),
    .wIdx   (wIdx),
    .rIdx   (rIdx),
    .oIdx   (oIdx)
  );

  tridiag_datapath #(.W(W), .FRAC(FRAC), .N(N), .IW(IW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .wIdx    (wIdx),
    .rIdx    (rIdx),
    .oIdx    (oIdx),
    .inAlpha (inAlpha),
    .inBeta  (inBeta),
    .inGamma (inGamma),
    .inD     (inD),
    .divDone (divDone),
    .outValid(outValid),
    .outLast (outLast),
    .outData (outData)
  );

endmodule

// File: rtl/tridiag_row_solver_chk.sv
module tridiag_row_solver_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic outValid,
  input logic outLast
);

  // R7
  stall_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R7
  stall_during_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |-> !inReady);

  // R8
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R8
  burst_contiguous_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> outValid);

  // R8
  burst_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> !outValid);

endmodule

bind tridiag_row_solver tridiag_row_solver_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .outValid(outValid),
  .outLast (outLast)
);

// File: tb/tb_tridiag_row_solver.sv
`timescale 1ns/1ps
module tb_tridiag_row_solver;
  localparam int N    = 5;
  localparam int W    = 16;
  localparam int FRAC = 8;
  localparam int NV   = 15;

  // {a, b, c, d} per element, three rows of N elements
  localparam logic [63:0] VEC [NV] = '{
    64'h0400_0100_0100_0100, 64'h0400_0100_0100_0200, 64'h0400_0100_0100_0300,
    64'h0400_0100_0100_0400, 64'h0400_0100_0100_0500,
    64'hFD00_0080_FF40_0280, 64'hFC80_FFA0_0060_FE80, 64'hFD40_0080_FF40_0040,
    64'hFE00_0133_FF11_FFC0, 64'hFD00_0080_FF40_0A00,
    64'h0020_7000_0800_4000, 64'h0100_8800_7F00_C000, 64'h0008_0400_F000_7FFF,
    64'hFFF0_7FFF_8000_8000, 64'h0300_0100_0100_1234
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inStart = 1'b0, inEnd = 1'b0;
  logic signed [W-1:0] inAlpha = '0, inBeta = '0, inGamma = '0, inD = '0;
  logic inReady, outValid, outLast;
  logic signed [W-1:0] outData;

  always #4 clk = ~clk;

  tridiag_row_solver #(.N(N), .W(W), .FRAC(FRAC)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inStart(inStart), .inEnd(inEnd), .inAlpha(inAlpha), .inBeta(inBeta),
    .inGamma(inGamma), .inD(inD), .outValid(outValid), .outLast(outLast),
    .outData(outData)
  );

  int nChecks = 0;
  int nFail = 0;
  int tA [8], tB [8], tG [8], tD [8], expU [8];
  int capU [128];
  bit capL [128];
  bit capR [128];
  int capN = 0;
  bit readyAfter;

  always @(negedge clk) begin
    if (outValid && capN < 128) begin
      capU[capN] = int'(outData);
      capL[capN] = outLast;
      capR[capN] = inReady;
      capN = capN + 1;
    end
  end

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction
  function automatic int fmul(int a, int b);
    return sat16((a * b) >>> FRAC);
  endfunction
  function automatic int fsub(int a, int b);
    return sat16(a - b);
  endfunction
  function automatic int fdiv(int p, int q);
    if (q == 0) return (p < 0) ? -32768 : 32767;
    return sat16((p * (1 << FRAC)) / q);
  endfunction

  task automatic buildModel(int len);
    int m [8];
    int y [8];
    int l;
    m[0] = tA[0];
    y[0] = tD[0];
    for (int i = 1; i < len; i++) begin
      l = fdiv(tG[i-1], m[i-1]);
      m[i] = fsub(tA[i], fmul(l, tB[i-1]));
      y[i] = fsub(tD[i], fmul(l, y[i-1]));
    end
    expU[len-1] = fdiv(y[len-1], m[len-1]);
    for (int i = len - 2; i >= 0; i--)
      expU[i] = fdiv(fsub(y[i], fmul(tB[i], expU[i+1])), m[i]);
  endtask

  task automatic checkEq(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic loadVec(int base);
    for (int i = 0; i < N; i++) begin
      tA[i] = int'($signed(VEC[base+i][63:48]));
      tB[i] = int'($signed(VEC[base+i][47:32]));
      tG[i] = int'($signed(VEC[base+i][31:16]));
      tD[i] = int'($signed(VEC[base+i][15:0]));
    end
  endtask

  task automatic sendElem(int a, int b, int g, int d, bit st, bit en);
    @(negedge clk);
    inAlpha = W'(a); inBeta = W'(b); inGamma = W'(g); inD = W'(d);
    inStart = st; inEnd = en; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    readyAfter = inReady;
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
  endtask

  task automatic sendRow(int len, string tag);
    int base;
    bit lastOk;
    base = capN;
    for (int i = 0; i < len; i++) begin
      sendElem(tA[i], tB[i], tG[i], tD[i], i == 0, i == len - 1);
      if (i == 0) checkEq("R7 stall after accept", int'(readyAfter), 0);
    end
    while (capN < base + len) @(negedge clk);
    repeat (4) @(negedge clk);
    buildModel(len);
    for (int j = 0; j < len; j++) checkEq(tag, capU[base+j], expU[j]);
    checkEq("R8 word count", capN - base, len);
    lastOk = capL[base+len-1];
    for (int j = 0; j < len - 1; j++) if (capL[base+j] || capR[base+j]) lastOk = 1'b0;
    checkEq("R8 R7 last flag and stall", int'(lastOk), 1);
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishUp();
  end

  initial begin
    int single [2];
    repeat (3) @(negedge clk);
    // R10 reset state
    checkEq("R10 inReady", int'(inReady), 1);
    checkEq("R10 outValid", int'(outValid), 0);
    checkEq("R10 outLast", int'(outLast), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R10 inReady after reset", int'(inReady), 1);

    // table walk: R1 R2 R4 on three coefficient patterns
    for (int r = 0; r < 3; r++) begin
      loadVec(r * N);
      sendRow(N, "R1 R2 R4 table row");
    end

    // R3: final b and c do not matter
    loadVec(0);
    tB[N-1] = 16'sh7777; tG[N-1] = -32767;
    sendRow(N, "R3 final b c ignored");

    // R5: partial row discarded on restart
    loadVec(N);
    sendElem(tA[0], tB[0], tG[0], tD[0], 1'b1, 1'b0);
    sendElem(tA[1], tB[1], tG[1], tD[1], 1'b0, 1'b0);
    loadVec(0);
    sendRow(N, "R5 restart");

    // R6: short row ended by marker
    loadVec(N);
    sendRow(3, "R6 short row");

    // R6: row ended by length limit with no end marker
    loadVec(2 * N);
    single[0] = capN;
    for (int i = 0; i < N; i++) sendElem(tA[i], tB[i], tG[i], tD[i], i == 0, 1'b0);
    while (capN < single[0] + N) @(negedge clk);
    repeat (4) @(negedge clk);
    buildModel(N);
    for (int j = 0; j < N; j++) checkEq("R6 length limit", capU[single[0]+j], expU[j]);
    checkEq("R6 R8 last at N", int'(capL[single[0]+N-1]), 1);

    // R3 truncation toward zero: 1.0/3.0 and -1.0/3.0
    tA[0] = 16'sh0300; tB[0] = 0; tG[0] = 0; tD[0] = 16'sh0100;
    sendRow(1, "R3 positive quotient");
    checkEq("R3 value 85", expU[0], 85);
    tD[0] = -256;
    sendRow(1, "R3 negative quotient");
    checkEq("R3 value -85", expU[0], -85);

    // R9: divide by zero, both signs
    tA[0] = 0; tD[0] = -256;
    single[1] = capN;
    sendRow(1, "R9 negative");
    checkEq("R9 negative saturation", capU[single[1]], -32768);
    tD[0] = 512;
    single[1] = capN;
    sendRow(1, "R9 positive");
    checkEq("R9 positive saturation", capU[single[1]], 32767);

    // R9 inside a row: zero first pivot
    tA[0] = 0; tB[0] = 16'sh0100; tG[0] = 16'sh0080; tD[0] = 16'sh0100;
    tA[1] = 16'sh0200; tB[1] = 0; tG[1] = 0; tD[1] = -300;
    sendRow(2, "R9 zero pivot row");

    finishUp();
  end

endmodule